// File: doc/BRIEF.md
# Memory Protection Register File with Flush Control

This block keeps the memory protection settings of a small in-order core. It holds one configuration byte and one address register for each protected region, plus a three-bit security register. When the core commits a CSR instruction, the block applies it to the addressed register. The instruction can write the register, set bits in it or clear bits in it. The block applies the region lock rules, the sticky security bits and the machine-mode privilege check.

Any committed CSR modification raises a one-cycle flush request, whichever register it targets. Bit-clear operations flush just like writes and sets. The flush matters because the next instruction may already have been fetched, and its execute permission was checked against the old protection state. The flush discards that instruction so it is fetched again under the new state. Loads and stores check their permissions when the memory access begins, so they always see the current state and need no flush.

A three-state controller produces both result pulses:
- ST_IDLE: no output.
- ST_FLUSH: drives the flush output.
- ST_DENY: drives the illegal-access output.

From any state, the next state follows from the input sampled at the clock edge:
- A committed modification that is permitted goes to ST_FLUSH (IDLE→FLUSH, FLUSH→FLUSH, DENY→FLUSH).
- A committed modification of a protection register below machine mode goes to ST_DENY (→DENY).
- Anything else returns to ST_IDLE (→IDLE).

Top module: `pmp_csr_ctrl`

## Requirements
- R1: The operation input encodes 0 = none, 1 = write, 2 = set-bits and 3 = clear-bits. A committed operation in machine mode updates the addressed register on the next edge as follows: write loads the operand, set ORs the operand in, and clear ANDs in the inverted operand. Operation 0 changes nothing. Each region's configuration byte takes operand bits [7:0], and each region's address register takes all 32 bits.
- R2: `flush_o` is high for exactly one cycle, in the cycle after a commit with a nonzero operation. This holds for any CSR address, including addresses that are not protection registers, for clear operations, and for an all-zero operand.
- R3: `flush_o` stays low when no commit occurs and when a commit carries operation 0.
- R4: A nonzero operation committed to a protection register with `priv_i` other than 3 (machine) changes no state. It pulses `illegal_o` in the following cycle and gives no flush.
- R5: A region whose configuration bit 7 (lock) is set ignores modifications of its configuration and address registers. The exception is when security bit 2 (bypass) is set, in which case the modifications apply.
- R6: Security bit 0 (lockdown) and bit 1 (whitelist policy) are sticky: once set, no write or clear returns them to 0. Security bits above bit 2 do not exist.
- R7: Security bit 2 (bypass) changes only while no region has its lock bit set; otherwise it holds its value.
- R8: Reset clears every configuration byte, address register and security bit, and both output pulses.
- R9: Commits on consecutive cycles produce a result pulse in each following cycle, with no dead cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | A CSR instruction commits in this cycle |
| csr_addr_i | input | 12 | CSR address: region config at CFG_BASE+i, region address at ADDR_BASE+i, security at SEC_ADDR |
| csr_op_i | input | 2 | 0 none, 1 write, 2 set-bits, 3 clear-bits |
| csr_wdata_i | input | 32 | Operand |
| priv_i | input | 2 | Current privilege level, 3 = machine |
| region_cfg_o | output | 32 | Config bytes, region i at bits [8i+7:8i] |
| region_addr_o | output | 128 | Address registers, region i at bits [32i+31:32i] |
| sec_cfg_o | output | 3 | Security bits: 0 lockdown, 1 whitelist, 2 bypass |
| flush_o | output | 1 | One-cycle pipeline flush request |
| illegal_o | output | 1 | One-cycle illegal-access pulse |

## Verification
The assertions assume that `commit_i` is a clean, registered, single-cycle strobe. They also assume that address, operation, operand and privilege are stable in the cycle of that strobe, so there are no glitching or X-valued inputs while committing.

The stimulus drives every input at the falling edge and holds it through the following rising edge. It raises the commit strobe only for one edge per operation, or for consecutive edges in the back-to-back case. It keeps reset asserted across whole clock cycles.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

    localparam int XLEN     = 32;
    localparam int CFG_W    = 8;
    localparam int LOCK_BIT = 7;
    localparam int SEC_W    = 3;
    localparam int SEC_LOCKDOWN  = 0;
    localparam int SEC_WHITELIST = 1;
    localparam int SEC_BYPASS    = 2;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef enum logic [1:0] {
        CSR_NONE  = 2'd0,
        CSR_WRITE = 2'd1,
        CSR_SET   = 2'd2,
        CSR_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DENY  = 2'd2
    } flush_state_e;

    function automatic logic [XLEN-1:0] csr_apply(csr_op_e op,
                                                  logic [XLEN-1:0] old,
                                                  logic [XLEN-1:0] arg);
        logic [XLEN-1:0] res;
        unique case (op)
            CSR_WRITE: res = arg;
            CSR_SET:   res = old | arg;
            CSR_CLEAR: res = old & ~arg;
            default:   res = old;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pmp_region_reg.sv
module pmp_region_reg
    import pmp_csr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_cfg_i,
    input  logic             wr_addr_i,
    input  csr_op_e          op_i,
    input  logic [XLEN-1:0]  data_i,
    input  logic             bypass_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [XLEN-1:0]  addr_o,
    output logic             locked_o
);

    logic [CFG_W-1:0] cfg_q;
    logic [XLEN-1:0]  addr_q;
    logic             may_change;
    logic [XLEN-1:0]  cfg_next_wide;
    logic [XLEN-1:0]  addr_next;

    assign locked_o   = cfg_q[LOCK_BIT];
    assign may_change = !(cfg_q[LOCK_BIT] && !bypass_i);

    always_comb begin
        cfg_next_wide = csr_apply(op_i, {{(XLEN-CFG_W){1'b0}}, cfg_q}, data_i);
        addr_next     = csr_apply(op_i, addr_q, data_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else begin
            if (wr_cfg_i && may_change) begin
                cfg_q <= cfg_next_wide[CFG_W-1:0];
            end
            if (wr_addr_i && may_change) begin
                addr_q <= addr_next;
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign addr_o = addr_q;

    // R5: a locked region without bypass keeps both registers
    a_r5_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && !bypass_i) |=> ($stable(cfg_o) && $stable(addr_o)));

    // R1: registers move only when addressed
    a_r1_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_cfg_i && !wr_addr_i) |=> ($stable(cfg_o) && $stable(addr_o)));

endmodule

// File: rtl/pmp_seccfg_reg.sv
module pmp_seccfg_reg
    import pmp_csr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  csr_op_e          op_i,
    input  logic [XLEN-1:0]  data_i,
    input  logic             any_locked_i,
    output logic [SEC_W-1:0] sec_o
);

    logic [SEC_W-1:0] sec_q;
    logic [SEC_W-1:0] sec_d;
    logic [XLEN-1:0]  applied;

    always_comb begin
        applied = csr_apply(op_i, {{(XLEN-SEC_W){1'b0}}, sec_q}, data_i);
        sec_d[SEC_LOCKDOWN]  = applied[SEC_LOCKDOWN]  | sec_q[SEC_LOCKDOWN];
        sec_d[SEC_WHITELIST] = applied[SEC_WHITELIST] | sec_q[SEC_WHITELIST];
        sec_d[SEC_BYPASS]    = any_locked_i ? sec_q[SEC_BYPASS] : applied[SEC_BYPASS];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sec_q <= '0;
        end else if (wr_i) begin
            sec_q <= sec_d;
        end
    end

    assign sec_o = sec_q;

    // R6: sticky bits never fall
    a_r6_lockdown_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_o[SEC_LOCKDOWN] |=> sec_o[SEC_LOCKDOWN]);
    a_r6_whitelist_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_o[SEC_WHITELIST] |=> sec_o[SEC_WHITELIST]);

    // R7: bypass frozen while any region is locked
    a_r7_bypass_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_locked_i |=> $stable(sec_o[SEC_BYPASS]));

endmodule

// File: rtl/pmp_flush_fsm.sv
module pmp_flush_fsm
    import pmp_csr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic commit_i,
    input  logic modify_i,
    input  logic prot_sel_i,
    input  logic priv_ok_i,
    output logic flush_o,
    output logic illegal_o
);

    flush_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (commit_i && modify_i) begin
            state_d = (prot_sel_i && !priv_ok_i) ? ST_DENY : ST_FLUSH;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flush_o   = 1'b0;
        illegal_o = 1'b0;
        unique case (state_q)
            ST_FLUSH: flush_o   = 1'b1;
            ST_DENY:  illegal_o = 1'b1;
            default: ;
        endcase
    end

    // R2: permitted modification gives a flush next cycle
    a_r2_flush_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && modify_i && (!prot_sel_i || priv_ok_i)) |=> flush_o);

    // R3: a flush always stems from a modifying commit
    a_r3_flush_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> $past(commit_i && modify_i));

    // R4: denied attempt pulses illegal and no flush
    a_r4_deny_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && modify_i && prot_sel_i && !priv_ok_i) |=> (illegal_o && !flush_o));

endmodule

// File: rtl/pmp_csr_ctrl.sv
module pmp_csr_ctrl
    import pmp_csr_pkg::*;
#(
    parameter int          NUM_REGIONS = 4,
    parameter logic [11:0] CFG_BASE    = 12'h3A0,
    parameter logic [11:0] ADDR_BASE   = 12'h3B0,
    parameter logic [11:0] SEC_ADDR    = 12'h390
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          commit_i,
    input  logic [11:0]                   csr_addr_i,
    input  logic [1:0]                    csr_op_i,
    input  logic [31:0]                   csr_wdata_i,
    input  logic [1:0]                    priv_i,
    output logic [NUM_REGIONS*8-1:0]      region_cfg_o,
    output logic [NUM_REGIONS*32-1:0]     region_addr_o,
    output logic [2:0]                    sec_cfg_o,
    output logic                          flush_o,
    output logic                          illegal_o
);

    localparam int CFG_TOTAL  = NUM_REGIONS * CFG_W;
    localparam int ADDR_TOTAL = NUM_REGIONS * XLEN;

    csr_op_e                op_e;
    logic                   modify;
    logic                   priv_ok;
    logic                   write_ok;
    logic [NUM_REGIONS-1:0] hit_cfg;
    logic [NUM_REGIONS-1:0] hit_addr;
    logic [NUM_REGIONS-1:0] locks;
    logic                   hit_sec;
    logic                   prot_sel;
    logic [CFG_TOTAL-1:0]   cfg_vec;
    logic [ADDR_TOTAL-1:0]  addr_vec;
    logic [SEC_W-1:0]       sec_vec;

    assign op_e     = csr_op_e'(csr_op_i);
    assign modify   = (op_e != CSR_NONE);
    assign priv_ok  = (priv_i == PRIV_MACHINE);
    assign write_ok = commit_i && modify && priv_ok;
    assign hit_sec  = (csr_addr_i == SEC_ADDR);
    assign prot_sel = (|hit_cfg) | (|hit_addr) | hit_sec;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        localparam logic [11:0] CFG_A  = CFG_BASE  + 12'(i);
        localparam logic [11:0] ADDR_A = ADDR_BASE + 12'(i);

        assign hit_cfg[i]  = (csr_addr_i == CFG_A);
        assign hit_addr[i] = (csr_addr_i == ADDR_A);

        pmp_region_reg u_region (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_cfg_i  (write_ok && hit_cfg[i]),
            .wr_addr_i (write_ok && hit_addr[i]),
            .op_i      (op_e),
            .data_i    (csr_wdata_i),
            .bypass_i  (sec_vec[SEC_BYPASS]),
            .cfg_o     (cfg_vec[i*CFG_W +: CFG_W]),
            .addr_o    (addr_vec[i*XLEN +: XLEN]),
            .locked_o  (locks[i])
        );
    end

    pmp_seccfg_reg u_sec (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_i         (write_ok && hit_sec),
        .op_i         (op_e),
        .data_i       (csr_wdata_i),
        .any_locked_i (|locks),
        .sec_o        (sec_vec)
    );

    pmp_flush_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .commit_i   (commit_i),
        .modify_i   (modify),
        .prot_sel_i (prot_sel),
        .priv_ok_i  (priv_ok),
        .flush_o    (flush_o),
        .illegal_o  (illegal_o)
    );

    assign region_cfg_o  = cfg_vec;
    assign region_addr_o = addr_vec;
    assign sec_cfg_o     = sec_vec;

    // R4: below machine mode nothing in the protection state changes
    a_r4_state_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && prot_sel && !priv_ok) |=>
        ($stable(region_cfg_o) && $stable(region_addr_o) && $stable(sec_cfg_o)));

    // R3: operation 0 never moves state
    a_r3_none_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!commit_i || !modify) |=>
        ($stable(region_cfg_o) && $stable(region_addr_o) && $stable(sec_cfg_o)));

endmodule

// File: tb/pmp_csr_ctrl_tb.sv
module pmp_csr_ctrl_tb_top;

    localparam int NR = 4;
    localparam logic [11:0] CB = 12'h3A0;
    localparam logic [11:0] AB = 12'h3B0;
    localparam logic [11:0] SB = 12'h390;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          commit = 1'b0;
    logic [11:0]   addr = '0;
    logic [1:0]    op = '0;
    logic [31:0]   wdata = '0;
    logic [1:0]    priv = 2'b11;
    logic [NR*8-1:0]  cfg_o;
    logic [NR*32-1:0] raddr_o;
    logic [2:0]    sec_o;
    logic          flush, illegal;

    always #10 clk = ~clk;

    pmp_csr_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .commit_i(commit), .csr_addr_i(addr),
        .csr_op_i(op), .csr_wdata_i(wdata), .priv_i(priv),
        .region_cfg_o(cfg_o), .region_addr_o(raddr_o), .sec_cfg_o(sec_o),
        .flush_o(flush), .illegal_o(illegal)
    );

    typedef struct {
        logic          fl;
        logic          il;
        logic [31:0]   cfg;
        logic [127:0]  ad;
        logic [2:0]    sec;
        string         tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0]  m_cfg [NR];
    logic [31:0] m_ad  [NR];
    logic [2:0]  m_sec;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " flush"},   128'(flush),   128'(e.fl));
            chk({e.tag, " illegal"}, 128'(illegal), 128'(e.il));
            chk({e.tag, " cfg"},     128'(cfg_o),   128'(e.cfg));
            chk({e.tag, " addr"},    raddr_o,       e.ad);
            chk({e.tag, " sec"},     128'(sec_o),   128'(e.sec));
        end
    end

    function automatic logic [31:0] m_apply(logic [1:0] o, logic [31:0] old, logic [31:0] d);
        if (o == 2'd1) return d;
        if (o == 2'd2) return old | d;
        if (o == 2'd3) return old & ~d;
        return old;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NR; i++) begin
            m_cfg[i] = '0;
            m_ad[i]  = '0;
        end
        m_sec = '0;
    endtask

    function automatic exp_t snap(logic f, logic il, string tag);
        exp_t e;
        e.fl = f; e.il = il; e.tag = tag; e.sec = m_sec;
        for (int i = 0; i < NR; i++) begin
            e.cfg[i*8 +: 8]   = m_cfg[i];
            e.ad[i*32 +: 32]  = m_ad[i];
        end
        return e;
    endfunction

    task automatic do_op(logic [1:0] o, logic [11:0] a, logic [31:0] d,
                         logic [1:0] p, logic c, string tag);
        logic f, il, prot, anyl;
        @(negedge clk);
        commit = c; op = o; addr = a; wdata = d; priv = p;
        prot = (a == SB);
        for (int i = 0; i < NR; i++)
            if (a == CB + 12'(i) || a == AB + 12'(i)) prot = 1'b1;
        f = 1'b0; il = 1'b0;
        if (c && o != 2'd0) begin
            if (prot && p != 2'b11) il = 1'b1;
            else begin
                f = 1'b1;
                anyl = 1'b0;
                for (int i = 0; i < NR; i++) anyl |= m_cfg[i][7];
                for (int i = 0; i < NR; i++) begin
                    if (!(m_cfg[i][7] && !m_sec[2])) begin
                        if (a == AB + 12'(i)) m_ad[i] = m_apply(o, m_ad[i], d);
                        if (a == CB + 12'(i)) m_cfg[i] = m_apply(o, {24'd0, m_cfg[i]}, d)[7:0];
                    end
                end
                if (a == SB) begin
                    logic [31:0] nv;
                    nv = m_apply(o, {29'd0, m_sec}, d);
                    nv[0] = nv[0] | m_sec[0];
                    nv[1] = nv[1] | m_sec[1];
                    if (anyl) nv[2] = m_sec[2];
                    m_sec = nv[2:0];
                end
            end
        end
        @(posedge clk);
        #1;
        commit = 1'b0; op = 2'd0;
        q.push_back(snap(f, il, tag));
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_ni = 1'b0; commit = 1'b0;
        m_reset();
        repeat (2) @(negedge clk);
        // R8: everything cleared while in reset
        chk({tag, " cfg"},   128'(cfg_o), 128'd0);
        chk({tag, " addr"},  raddr_o,     128'd0);
        chk({tag, " sec"},   128'(sec_o), 128'd0);
        chk({tag, " flush"}, 128'(flush), 128'd0);
        rst_ni = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_reset();
        do_reset("R8 reset");
        // R1 basic operations
        do_op(2'd1, CB,         32'h0000_000F, 2'b11, 1, "R1 write cfg0");
        do_op(2'd1, AB,         32'h1234_5678, 2'b11, 1, "R1 write addr0");
        do_op(2'd2, CB,         32'h0000_0010, 2'b11, 1, "R1 set cfg0");
        do_op(2'd3, CB,         32'h0000_0003, 2'b11, 1, "R2 clear cfg0 flushes");
        do_op(2'd3, AB,         32'h0000_0000, 2'b11, 1, "R2 zero clear flushes");
        do_op(2'd2, AB + 12'd3, 32'hF000_0001, 2'b11, 1, "R1 set addr3");
        do_op(2'd0, CB,         32'hFFFF_FFFF, 2'b11, 1, "R3 none op");
        do_op(2'd1, CB,         32'hFFFF_FFFF, 2'b11, 0, "R3 no commit");
        do_op(2'd1, 12'h300,    32'h0000_0008, 2'b11, 1, "R2 other CSR flush");
        do_op(2'd1, 12'h300,    32'h0000_0008, 2'b00, 1, "R2 other CSR user");
        // R4 lower privilege
        do_op(2'd1, CB + 12'd1, 32'h0000_0007, 2'b00, 1, "R4 user cfg1");
        do_op(2'd2, SB,         32'h0000_0001, 2'b01, 1, "R4 super sec");
        // R7 bypass toggles when unlocked
        do_op(2'd2, SB,         32'h0000_0004, 2'b11, 1, "R7 bypass set");
        do_op(2'd3, SB,         32'h0000_0004, 2'b11, 1, "R7 bypass clear");
        // R5 lock without bypass
        do_op(2'd1, CB + 12'd1, 32'h0000_0085, 2'b11, 1, "R5 lock cfg1");
        do_op(2'd1, CB + 12'd1, 32'h0000_0000, 2'b11, 1, "R5 locked cfg ignored");
        do_op(2'd1, AB + 12'd1, 32'hDEAD_BEEF, 2'b11, 1, "R5 locked addr ignored");
        do_op(2'd2, SB,         32'h0000_0004, 2'b11, 1, "R7 bypass held");
        do_reset("R8 second reset");
        // R5 with bypass
        do_op(2'd2, SB,         32'h0000_0004, 2'b11, 1, "R7 bypass set again");
        do_op(2'd1, CB + 12'd2, 32'h0000_0081, 2'b11, 1, "R5 lock cfg2");
        do_op(2'd1, AB + 12'd2, 32'hCAFE_0000, 2'b11, 1, "R5 bypass addr write");
        do_op(2'd3, SB,         32'h0000_0004, 2'b11, 1, "R7 bypass frozen");
        do_op(2'd1, CB + 12'd2, 32'h0000_0003, 2'b11, 1, "R5 bypass unlock");
        // R6 sticky bits
        do_op(2'd2, SB,         32'h0000_0001, 2'b11, 1, "R6 set lockdown");
        do_op(2'd1, SB,         32'h0000_0000, 2'b11, 1, "R6 write zero");
        do_op(2'd2, SB,         32'h0000_0002, 2'b11, 1, "R6 set whitelist");
        do_op(2'd3, SB,         32'hFFFF_FFFF, 2'b11, 1, "R6 clear all");
        do_op(2'd1, SB,         32'hFFFF_FFF8, 2'b11, 1, "R6 upper bits");
        // R9 back to back
        do_op(2'd1, AB + 12'd3, 32'h0000_1111, 2'b11, 1, "R9 burst 1");
        do_op(2'd3, AB + 12'd3, 32'h0000_0001, 2'b11, 1, "R9 burst 2");
        do_op(2'd1, CB + 12'd3, 32'h0000_0007, 2'b00, 1, "R9 burst deny");
        do_op(2'd2, CB + 12'd3, 32'h0000_0004, 2'b11, 1, "R9 burst 3");
        do_op(2'd0, CB,         32'h0,         2'b11, 0, "R3 idle tail");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule